// File: doc/BRIEF.md
# Lifting 9/7 Wavelet Row Filter

This block performs a one-dimensional forward biorthogonal 9/7 wavelet transform on one row of signed samples. It uses the lifting factorisation. A row of even length is first captured into a local store. The store is split by index parity into even and odd samples. Four lifting passes then run: a predict pass, an update pass, a second predict pass and a second update pass. Each pass rewrites one parity class in place from its two neighbours of the other class. Missing neighbours at the two row ends are supplied by whole-sample symmetric mirroring. A final scaling multiplies the even samples by K to give approximation coefficients and the odd samples by 1/K to give detail coefficients. The coefficients leave as pairs, one approximation and one detail per beat.

The data path is signed fixed point. Lifting and scaling constants are held with 14 fractional bits. Inside the block each sample carries 4 extra fractional bits and 3 headroom bits. Every lifting result is rounded to nearest and clamped. The outputs drop the extra fractional bits with rounding to nearest, so an output LSB equals an input LSB.

Samples enter on a valid/ready pair and coefficient pairs leave on a valid/ready pair. A sample or a pair moves only in a cycle where both valid and ready are high. The upstream side may hold valid low for any number of cycles. The downstream side may hold ready low for any number of cycles, and the block then keeps its output stable. A one-cycle row-start pulse loads a new row length and restarts the block from any state.

Top module: `wl97_row_filter`

## Requirements
- R1: While reset is high, and in the first cycle after it, `in_ready` and `out_valid` are both low.
- R2: After a `row_start` pulse with an even `row_len` L in the range 2 to MAX_N, `in_ready` is high from the next cycle. It stays high until exactly L samples have been accepted, then goes low.
- R3: A sample is taken only in a cycle where `in_valid` and `in_ready` are both high. Idle cycles with `in_valid` low between samples do not change the coefficients produced.
- R4: Sample k of the row is X(k). The block forms d1 = Xo(n) + alpha*(Xe(n)+Xe(n+1)), then a1 = Xe(n) + beta*(d1(n-1)+d1(n)), then d2 = d1(n) + gamma*(a1(n)+a1(n+1)), then a2 = a1(n) + delta*(d2(n-1)+d2(n)). Here Xe(n)=X(2n), Xo(n)=X(2n+1), alpha=-1.586134342, beta=-0.05298011854, gamma=0.8829110762 and delta=0.4435068522. For inputs within ±4096, `out_approx` lies within ±2 LSB of the real-valued result.
- R5: At the row ends, a missing neighbour index -1 is replaced by index 1, and a missing index L by index L-2. This holds at every lifting step.
- R6: `out_approx` equals K*a2(n) and `out_detail` equals d2(n)/K, with K=1.149604398, each within ±2 LSB for inputs within ±4096.
- R7: A row produces exactly L/2 output beats, ordered by ascending n. `out_last` is high on the final beat only and is never high without `out_valid`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_approx`, `out_detail` and `out_last` hold their values in the next cycle.
- R9: A `row_start` pulse in any state abandons the current row. In the next cycle `out_valid` is low and `in_ready` is high.
- R10: `in_ready` and `out_valid` are never high together. After the final beat of a row is accepted, both stay low until the next `row_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| row_start | input | 1 | One-cycle pulse that starts a new row and captures `row_len` |
| row_len | input | $clog2(MAX_N+1) | Even row length, 2 to MAX_N |
| in_valid | input | 1 | Input sample is valid |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | IN_W | Signed input sample |
| out_valid | output | 1 | Coefficient pair is valid |
| out_ready | input | 1 | Downstream accepts the pair this cycle |
| out_approx | output | IN_W+3 | Signed approximation coefficient a(n) |
| out_detail | output | IN_W+3 | Signed detail coefficient d(n) |
| out_last | output | 1 | Marks the final pair of the row |

## Verification
The boundary mirroring is the hardest part to reach. It touches only the first and last pair of a row, and only when energy sits within a few samples of an edge. A sweep of all even short row lengths places a single impulse at every position in turn. This makes every lifting step read a mirrored neighbour with a nonzero value at both ends. Row aborts need a restart pulse in the middle of loading and in the middle of output. The bench then confirms that the following row is clean. Input gaps and output stalls are interleaved across the sweep, so the hold rules are exercised at both ends.

// File: rtl/wl97_pkg.sv
package wl97_pkg;

  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  // lifting and scaling constants, value * 2^14 rounded to nearest
  localparam logic signed [COEF_W-1:0] C_ALPHA = -16'sd25987;
  localparam logic signed [COEF_W-1:0] C_BETA  = -16'sd868;
  localparam logic signed [COEF_W-1:0] C_GAMMA =  16'sd14466;
  localparam logic signed [COEF_W-1:0] C_DELTA =  16'sd7266;
  localparam logic signed [COEF_W-1:0] C_K     =  16'sd18835;
  localparam logic signed [COEF_W-1:0] C_KINV  =  16'sd14252;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LOAD,
    ST_LIFT,
    ST_EMIT
  } wl_state_t;

  // pass order: odd predict, even update, odd predict, even update
  function automatic logic signed [COEF_W-1:0] lift_coef(input logic [1:0] pass);
    case (pass)
      2'd0:    lift_coef = C_ALPHA;
      2'd1:    lift_coef = C_BETA;
      2'd2:    lift_coef = C_GAMMA;
      default: lift_coef = C_DELTA;
    endcase
  endfunction

endpackage

// File: rtl/wl97_lift_alu.sv
module wl97_lift_alu #(
  parameter int W     = 23,
  parameter int CW    = 16,
  parameter int CFRAC = 14
) (
  input  logic signed [W-1:0]  ctr,
  input  logic signed [W-1:0]  nb_l,
  input  logic signed [W-1:0]  nb_r,
  input  logic signed [CW-1:0] coef,
  output logic signed [W-1:0]  res
);

  localparam int PW = W + CW + 1;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (CFRAC - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (W - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(64'sd1);

  logic signed [PW-1:0] pair_sum;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] acc;

  // one multiply and two additions per step
  always_comb begin
    pair_sum = PW'(nb_l) + PW'(nb_r);
    prod     = pair_sum * PW'(coef);
    acc      = PW'(ctr) + ((prod + HALF) >>> CFRAC);
    if (acc > MAXV)      res = MAXV[W-1:0];
    else if (acc < MINV) res = MINV[W-1:0];
    else                 res = acc[W-1:0];
  end

endmodule

// File: rtl/wl97_scale.sv
module wl97_scale #(
  parameter int W     = 23,
  parameter int OW    = 19,
  parameter int FRAC  = 4,
  parameter int CW    = 16,
  parameter int CFRAC = 14
) (
  input  logic signed [W-1:0]  val,
  input  logic signed [CW-1:0] coef,
  output logic signed [OW-1:0] res
);

  localparam int PW = W + CW;
  localparam int SH = CFRAC + FRAC;
  localparam logic signed [PW-1:0] HALF = PW'(64'sd1 <<< (SH - 1));
  localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (OW - 1)) - 64'sd1);
  localparam logic signed [PW-1:0] MINV = -MAXV - PW'(64'sd1);

  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] acc;

  always_comb begin
    prod = PW'(val) * PW'(coef);
    acc  = (prod + HALF) >>> SH;
    if (acc > MAXV)      res = MAXV[OW-1:0];
    else if (acc < MINV) res = MINV[OW-1:0];
    else                 res = acc[OW-1:0];
  end

endmodule

// File: rtl/wl97_row_store.sv
module wl97_row_store #(
  parameter int DEPTH = 256,
  parameter int W     = 23,
  parameter int NRD   = 3,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [AW-1:0]            waddr,
  input  logic [W-1:0]             wdata,
  input  logic [NRD-1:0][AW-1:0]   raddr,
  output logic [NRD-1:0][W-1:0]    rdata
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata[p] = mem[raddr[p]];
  end

endmodule

// File: rtl/wl97_ctrl.sv
module wl97_ctrl
  import wl97_pkg::*;
#(
  parameter int MAX_N = 256,
  localparam int LW   = $clog2(MAX_N + 1),
  localparam int AW   = $clog2(MAX_N)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 row_start,
  input  logic [LW-1:0]        row_len,
  input  logic                 in_valid,
  input  logic                 out_ready,
  output logic                 in_ready,
  output logic                 out_valid,
  output logic                 out_last,
  output logic [1:0]           pass,
  output logic                 we,
  output logic                 load_sel,
  output logic [AW-1:0]        waddr,
  output logic [2:0][AW-1:0]   raddr
);

  wl_state_t   st_q;
  logic [LW-1:0] len_q;
  logic [LW-1:0] cnt_q;
  logic [1:0]    pass_q;
  logic [LW-1:0] half;
  logic [LW-1:0] tgt;
  logic [LW-1:0] even_i;
  logic [LW-1:0] odd_i;
  logic [LW-1:0] nb_l;
  logic [LW-1:0] nb_r;
  logic          cnt_end;

  assign half    = len_q >> 1;
  assign even_i  = {cnt_q[LW-2:0], 1'b0};
  assign odd_i   = {cnt_q[LW-2:0], 1'b1};
  assign cnt_end = (cnt_q == half - LW'(1));

  // even passes rewrite odd slots, odd passes rewrite even slots
  always_comb begin
    tgt  = pass_q[0] ? even_i : odd_i;
    nb_l = (tgt == '0) ? LW'(1) : tgt - LW'(1);
    nb_r = ((tgt + LW'(1)) == len_q) ? len_q - LW'(2) : tgt + LW'(1);
  end

  assign in_ready  = (st_q == ST_LOAD);
  assign out_valid = (st_q == ST_EMIT);
  assign out_last  = out_valid && cnt_end;
  assign pass      = pass_q;
  assign load_sel  = (st_q == ST_LOAD);
  assign we        = (load_sel && in_valid) || (st_q == ST_LIFT);
  assign waddr     = load_sel ? cnt_q[AW-1:0] : tgt[AW-1:0];

  always_comb begin
    if (st_q == ST_EMIT) begin
      raddr[0] = even_i[AW-1:0];
      raddr[1] = odd_i[AW-1:0];
      raddr[2] = odd_i[AW-1:0];
    end else begin
      raddr[0] = tgt[AW-1:0];
      raddr[1] = nb_l[AW-1:0];
      raddr[2] = nb_r[AW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      len_q  <= '0;
      cnt_q  <= '0;
      pass_q <= '0;
    end else if (row_start) begin
      st_q   <= ST_LOAD;
      len_q  <= row_len;
      cnt_q  <= '0;
      pass_q <= '0;
    end else begin
      case (st_q)
        ST_LOAD: begin
          if (in_valid) begin
            if (cnt_q == len_q - LW'(1)) begin
              st_q  <= ST_LIFT;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + LW'(1);
            end
          end
        end
        ST_LIFT: begin
          if (cnt_end) begin
            cnt_q <= '0;
            if (pass_q == 2'd3) st_q <= ST_EMIT;
            else                pass_q <= pass_q + 2'd1;
          end else begin
            cnt_q <= cnt_q + LW'(1);
          end
        end
        ST_EMIT: begin
          if (out_ready) begin
            if (cnt_end) begin
              st_q  <= ST_IDLE;
              cnt_q <= '0;
            end else begin
              cnt_q <= cnt_q + LW'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wl97_row_filter.sv
module wl97_row_filter
  import wl97_pkg::*;
#(
  parameter int IN_W   = 16,
  parameter int FRAC_W = 4,
  parameter int HEAD_W = 3,
  parameter int MAX_N  = 256,
  localparam int LW    = $clog2(MAX_N + 1),
  localparam int OUT_W = IN_W + HEAD_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    row_start,
  input  logic [LW-1:0]           row_len,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_approx,
  output logic signed [OUT_W-1:0] out_detail,
  output logic                    out_last
);

  localparam int W  = IN_W + FRAC_W + HEAD_W;
  localparam int AW = $clog2(MAX_N);

  logic [1:0]              pass;
  logic                    we;
  logic                    load_sel;
  logic [AW-1:0]           waddr;
  logic [2:0][AW-1:0]      raddr;
  logic [2:0][W-1:0]       rdata;
  logic signed [W-1:0]     load_word;
  logic signed [W-1:0]     lift_res;
  logic [W-1:0]            wdata;
  logic signed [OUT_W-1:0] scaled [2];

  wl97_ctrl #(.MAX_N(MAX_N)) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .row_start (row_start),
    .row_len   (row_len),
    .in_valid  (in_valid),
    .out_ready (out_ready),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_last  (out_last),
    .pass      (pass),
    .we        (we),
    .load_sel  (load_sel),
    .waddr     (waddr),
    .raddr     (raddr)
  );

  assign load_word = W'(in_data) <<< FRAC_W;
  assign wdata     = load_sel ? load_word : lift_res;

  wl97_row_store #(.DEPTH(MAX_N), .W(W), .NRD(3)) u_store (
    .clk   (clk),
    .we    (we),
    .waddr (waddr),
    .wdata (wdata),
    .raddr (raddr),
    .rdata (rdata)
  );

  wl97_lift_alu #(.W(W), .CW(COEF_W), .CFRAC(COEF_FRAC)) u_alu (
    .ctr  ($signed(rdata[0])),
    .nb_l ($signed(rdata[1])),
    .nb_r ($signed(rdata[2])),
    .coef (lift_coef(pass)),
    .res  (lift_res)
  );

  for (genvar g = 0; g < 2; g++) begin : g_scale
    localparam logic signed [COEF_W-1:0] GAIN = (g == 0) ? C_K : C_KINV;
    wl97_scale #(
      .W(W), .OW(OUT_W), .FRAC(FRAC_W), .CW(COEF_W), .CFRAC(COEF_FRAC)
    ) u_scale (
      .val  ($signed(rdata[g])),
      .coef (GAIN),
      .res  (scaled[g])
    );
  end

  assign out_approx = scaled[0];
  assign out_detail = scaled[1];

endmodule

// File: rtl/wl97_row_filter_chk.sv
module wl97_row_filter_chk #(
  parameter int LW    = 9,
  parameter int OUT_W = 19
) (
  input logic             clk,
  input logic             rst,
  input logic             row_start,
  input logic [LW-1:0]    row_len,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic             out_ready,
  input logic             out_last,
  input logic [OUT_W-1:0] out_approx,
  input logic [OUT_W-1:0] out_detail
);

  logic [LW-1:0] len_q;
  logic [LW-1:0] acc_q;
  logic [LW-1:0] beats_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      len_q   <= '0;
      acc_q   <= '0;
      beats_q <= '0;
    end else if (row_start) begin
      len_q   <= row_len;
      acc_q   <= '0;
      beats_q <= '0;
    end else begin
      if (in_valid && in_ready)   acc_q   <= acc_q + LW'(1);
      if (out_valid && out_ready) beats_q <= beats_q + LW'(1);
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (!in_ready && !out_valid));

  // R2
  start_opens_chk: assert property (@(posedge clk) disable iff (rst)
    row_start |=> in_ready);

  // R2
  load_closes_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && !row_start && ((acc_q + LW'(1)) == len_q)) |=> !in_ready);

  // R7
  last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    out_last |-> out_valid);

  // R7
  beat_count_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && out_last) |-> ((beats_q + LW'(1)) == (len_q >> 1)));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready && !row_start) |=>
      (out_valid && $stable(out_approx) && $stable(out_detail) && $stable(out_last)));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (rst)
    row_start |=> !out_valid);

  // R10
  phase_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(in_ready && out_valid));

endmodule

bind wl97_row_filter wl97_row_filter_chk #(.LW(LW), .OUT_W(OUT_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .row_start  (row_start),
  .row_len    (row_len),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_last   (out_last),
  .out_approx (out_approx),
  .out_detail (out_detail)
);

// File: tb/sim_wl97_row_filter.sv
module sim_wl97_row_filter;

  localparam int IN_W  = 16;
  localparam int MAX_N = 256;
  localparam int LW    = $clog2(MAX_N + 1);
  localparam int OUT_W = IN_W + 3;

  localparam real ALPHA = -1.586134342;
  localparam real BETA  = -0.05298011854;
  localparam real GAMMA = 0.8829110762;
  localparam real DELTA = 0.4435068522;
  localparam real KSC   = 1.149604398;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                    rst = 1'b1;
  logic                    row_start = 1'b0;
  logic [LW-1:0]           row_len = '0;
  logic                    in_valid = 1'b0;
  logic                    in_ready;
  logic signed [IN_W-1:0]  in_data = '0;
  logic                    out_valid;
  logic                    out_ready = 1'b1;
  logic signed [OUT_W-1:0] out_approx;
  logic signed [OUT_W-1:0] out_detail;
  logic                    out_last;

  wl97_row_filter #(.IN_W(IN_W), .MAX_N(MAX_N)) u0 (
    .clk(clk), .rst(rst), .row_start(row_start), .row_len(row_len),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_approx(out_approx), .out_detail(out_detail), .out_last(out_last)
  );

  int  n_chk = 0;
  int  n_fail = 0;
  int  stim [MAX_N];
  real ref_a [MAX_N/2];
  real ref_d [MAX_N/2];
  logic [31:0] lfsr = 32'h1D2C_3B4A;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic check_near(input string req, input int act, input real exp);
    real diff;
    diff = real'(act) - exp;
    if (diff < 0.0) diff = -diff;
    n_chk++;
    if (diff > 2.0) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %f", req, act, exp);
    end
  endtask

  function automatic int mir(input int i, input int len);
    if (i < 0) return -i;
    if (i >= len) return 2 * len - 2 - i;
    return i;
  endfunction

  function automatic void build_ref(input int len);
    real x [MAX_N];
    real c [4];
    c[0] = ALPHA; c[1] = BETA; c[2] = GAMMA; c[3] = DELTA;
    for (int i = 0; i < len; i++) x[i] = real'(stim[i]);
    for (int s = 0; s < 4; s++) begin
      for (int i = (s % 2 == 0) ? 1 : 0; i < len; i += 2)
        x[i] = x[i] + c[s] * (x[mir(i - 1, len)] + x[mir(i + 1, len)]);
    end
    for (int n = 0; n < len / 2; n++) begin
      ref_a[n] = KSC * x[2 * n];
      ref_d[n] = x[2 * n + 1] / KSC;
    end
  endfunction

  function automatic int next_rand();
    lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
    return int'($signed(lfsr[12:0]));
  endfunction

  task automatic pulse_start(input int len);
    @(negedge clk);
    row_start = 1'b1;
    row_len   = LW'(len);
    @(negedge clk);
    row_start = 1'b0;
  endtask

  task automatic feed(input int len, input bit gaps);
    for (int k = 0; k < len; k++) begin
      if (gaps && (k % 3 == 1)) begin
        in_valid = 1'b0;
        @(negedge clk);
      end
      if (k == len - 1) check(in_ready == 1'b1, "R2 ready before last", int'(in_ready), 1);
      in_valid = 1'b1;
      in_data  = IN_W'(stim[k]);
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic collect(input int len, input bit stall, input string tag);
    int w = 0;
    int a0, d0;
    while (!out_valid && w < 5000) begin
      @(negedge clk);
      w++;
    end
    check(out_valid == 1'b1, "R4 output appears", int'(out_valid), 1);
    for (int n = 0; n < len / 2; n++) begin
      if (stall && (n % 2 == 0)) begin
        out_ready = 1'b0;
        a0 = int'(out_approx);
        d0 = int'(out_detail);
        @(negedge clk);
        check(out_valid && int'(out_approx) == a0 && int'(out_detail) == d0,
              "R8 hold under stall", int'(out_approx), a0);
        out_ready = 1'b1;
      end
      check_near((n == 0 || n == len / 2 - 1) ? "R5 edge approx" : tag,
                 int'(out_approx), ref_a[n]);
      check_near("R6 detail", int'(out_detail), ref_d[n]);
      check(out_last == (n == len / 2 - 1), "R7 last flag", int'(out_last),
            int'(n == len / 2 - 1));
      @(negedge clk);
    end
    check(!out_valid && !in_ready, "R10 quiet after row", int'(out_valid) + int'(in_ready), 0);
  endtask

  task automatic run_row(input int len, input bit stall, input bit gaps, input string tag);
    build_ref(len);
    pulse_start(len);
    check(in_ready == 1'b1, "R2 ready after start", int'(in_ready), 1);
    feed(len, gaps);
    check(in_ready == 1'b0, gaps ? "R3 count with gaps" : "R2 closed after L",
          int'(in_ready), 0);
    collect(len, stall, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid, "R1 in reset", int'(in_ready) + int'(out_valid), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!in_ready && !out_valid, "R1 after reset", int'(in_ready) + int'(out_valid), 0);

    // impulse sweep over short rows, every position
    for (int len = 2; len <= 16; len += 2) begin
      for (int p = 0; p < len; p++) begin
        for (int i = 0; i < len; i++) stim[i] = 0;
        stim[p] = (p % 2 == 1) ? -3000 : 3000;
        run_row(len, p % 2 == 1, p % 3 == 0, "R4 impulse");
      end
      for (int i = 0; i < len; i++) stim[i] = 2500;
      run_row(len, 1'b0, 1'b0, "R4 constant");
      for (int i = 0; i < len; i++) stim[i] = (i % 2 == 0) ? 4000 : -4000;
      run_row(len, 1'b1, 1'b0, "R4 alternating");
      for (int i = 0; i < len; i++) stim[i] = 250 * i - 1800;
      run_row(len, 1'b0, 1'b1, "R4 ramp");
      for (int i = 0; i < len; i++) stim[i] = next_rand();
      run_row(len, 1'b1, 1'b1, "R3 random gaps");
    end

    // full-length rows
    for (int i = 0; i < MAX_N; i++) stim[i] = next_rand();
    run_row(MAX_N, 1'b1, 1'b1, "R4 long random");
    for (int i = 0; i < MAX_N - 2; i++) stim[i] = (i * 37) % 4001 - 2000;
    run_row(MAX_N - 2, 1'b0, 1'b0, "R4 long pattern");

    // abort while loading
    pulse_start(8);
    for (int k = 0; k < 3; k++) begin
      in_valid = 1'b1;
      in_data  = IN_W'(3999);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int i = 0; i < 4; i++) stim[i] = 700 - 450 * i;
    run_row(4, 1'b0, 1'b0, "R9 after load abort");

    // abort while emitting
    for (int i = 0; i < 6; i++) stim[i] = next_rand();
    pulse_start(6);
    feed(6, 1'b0);
    while (!out_valid) @(negedge clk);
    @(negedge clk);
    out_ready = 1'b0;
    row_start = 1'b1;
    row_len   = LW'(4);
    @(negedge clk);
    row_start = 1'b0;
    check(!out_valid && in_ready, "R9 abort in output", int'(out_valid), 0);
    out_ready = 1'b1;
    for (int i = 0; i < 4; i++) stim[i] = -1200 + 900 * i;
    run_row(4, 1'b1, 1'b0, "R9 after output abort");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule